// File: doc/BRIEF.md
# Dual Comparator Fault Monitor

This block watches the digital results of two voltage comparators and turns them into a fault indication for the rest of the system. Each channel can treat either a low comparator result (undervoltage) or a high one (overvoltage) as its fault condition. A programmable glitch filter sits behind each channel, so only a condition that persists for the selected time reaches the output. The filtered faults drive an active-low, open-drain style fault pin. They also feed a small status word that holds live fault bits and sticky latched bits.

The latched bits are set by one of two selectable events. The first event is the fault pin turning active, which is a leading-edge event only. The second is an external ready line being pulled low, and that event is armed only by certain margin-state moves. An optional mode keeps the fault pin released while the supply is margined high or low. A one-cycle clear strobe from the register interface empties the latched bits.

Top module: `dual_fault_monitor`

## Requirements
- R1: A channel whose polarity bit is 1 flags a fault while its comparator input is 1 (overvoltage). A channel whose polarity bit is 0 flags a fault while its comparator input is 0 (undervoltage).
- R2: The 3-bit filter code of a channel selects the filter time. Codes 0 to 7 give 0, 10, 20, 40, 80, 100, 120 and 140 ms, and one ms is CYC_PER_MS clock cycles. The filtered fault changes only after the raw fault level has held its new value for the whole filter time. This applies in both directions, and shorter pulses are dropped.
- R3: fault_n is 0 while any filtered fault is present and not suppressed, and 1 otherwise. It follows one clock after the live status.
- R4: stat_live bit i equals the filtered fault of channel i (1 = fault, 0 = no fault).
- R5: The margin state uses 00 = off, 01 = nominal, 10 = high and 11 = low. With cfg_supp_margin = 1, fault_n stays 1 in the high and low states. It is not suppressed in the off and nominal states.
- R6: With cfg_latch_on_ready = 0, the live bits are ORed into stat_lat when the fault output turns active. This happens on the leading edge only. A fault that persists, or a second channel faulting while the output is already active, does not latch again. A latched bit cleared during a fault therefore stays clear.
- R7: A pulse on lat_clr clears both latched bits. A latch event in the same cycle takes priority.
- R8: With cfg_latch_on_ready = 1, a falling edge of ready_in (after a 2-stage synchroniser) ORs the live bits into stat_lat. The most recent margin move must have been off to high, low or nominal; nominal to high or low; or high or low to nominal.
- R9: With cfg_latch_on_ready = 1, a ready_in fall does nothing in these cases: after a move into off, after a high-to-low or low-to-high move, or when no margin move has happened since reset. A leading edge of the fault output does not latch in this mode.
- R10: After reset, fault_n = 1, stat_live = 00 and stat_lat = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | NCH | Raw comparator levels, asynchronous |
| cfg_ov_sel | input | NCH | Per-channel polarity, 1 = overvoltage |
| cfg_filt_sel | input | 3*NCH | Per-channel filter code, channel i at bits [3i+2:3i] |
| cfg_supp_margin | input | 1 | Suppress fault output while margined high/low |
| cfg_latch_on_ready | input | 1 | Latch event select: 0 = fault edge, 1 = ready fall |
| margin_state | input | 2 | Current margin state |
| ready_in | input | 1 | Ready line level, asynchronous |
| lat_clr | input | 1 | One-cycle clear of latched bits |
| fault_n | output | 1 | Active-low fault output |
| stat_live | output | NCH | Live filtered fault bits |
| stat_lat | output | NCH | Latched fault bits |

## Verification
The bench first applies steady comparator patterns across every mix of polarity settings and every margin state, with suppression both on and off. These patterns separate a polarity inversion from a suppression error. Every filter code is then timed in both the assert and the release direction, and a short pulse shows that rejection does not depend on the direction of the edge. The latch tests walk through clearing during a persistent fault, a second channel faulting under an active output, and a sequence of margin moves. That sequence shows which moves arm the ready-triggered latch and which disarm it.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

  typedef enum logic [1:0] {
    MG_OFF  = 2'b00,
    MG_NOM  = 2'b01,
    MG_HIGH = 2'b10,
    MG_LOW  = 2'b11
  } margin_e;

  localparam int unsigned FSEL_W = 3;
  localparam int unsigned MAX_MS = 140;

  // filter window in ms for a channel filter code
  function automatic int unsigned filt_ms(input logic [FSEL_W-1:0] code);
    int unsigned ms;
    case (code)
      3'd0:    ms = 0;
      3'd1:    ms = 10;
      3'd2:    ms = 20;
      3'd3:    ms = 40;
      3'd4:    ms = 80;
      3'd5:    ms = 100;
      3'd6:    ms = 120;
      default: ms = 140;
    endcase
    return ms;
  endfunction

  // whether a margin move (from != to) arms the ready-triggered latch
  function automatic logic move_arms(input margin_e from, input margin_e to);
    logic ok;
    case (from)
      MG_OFF:  ok = (to != MG_OFF);
      MG_NOM:  ok = (to == MG_HIGH) || (to == MG_LOW);
      default: ok = (to == MG_NOM);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
  parameter int unsigned  W       = 1,
  parameter int unsigned  STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fmon_glitch_filter.sv
module fmon_glitch_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o
);

  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (raw_i == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q >= limit_i) begin
      filt_d = raw_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  // R2: the filtered level only ever moves to the value the raw level had
  a_r2_toward_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(raw_i) == filt_q));

  // R2: agreement between raw and filtered level freezes the output
  a_r2_hold_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/fmon_latch_ctl.sv
module fmon_latch_ctl
  import fmon_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] live_i,
  input  logic           fault_act_i,
  input  logic           ready_s_i,
  input  margin_e        margin_i,
  input  logic           use_ready_i,
  input  logic           clr_i,
  output logic [NCH-1:0] lat_o
);

  logic           fault_act_q;
  logic           ready_q;
  margin_e        margin_q;
  logic           arm_q, arm_d;
  logic [NCH-1:0] lat_q, lat_d;
  logic           fault_rise, ready_fall, evt;

  always_comb begin
    fault_rise = fault_act_i & ~fault_act_q;
    ready_fall = ready_q & ~ready_s_i;
    evt        = use_ready_i ? (ready_fall & arm_q) : fault_rise;

    arm_d = arm_q;
    if (margin_i != margin_q) arm_d = move_arms(margin_q, margin_i);

    lat_d = (clr_i ? '0 : lat_q) | (evt ? live_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_act_q <= 1'b0;
      ready_q     <= 1'b1;
      margin_q    <= MG_OFF;
      arm_q       <= 1'b0;
      lat_q       <= '0;
    end else begin
      fault_act_q <= fault_act_i;
      ready_q     <= ready_s_i;
      margin_q    <= margin_i;
      arm_q       <= arm_d;
      lat_q       <= lat_d;
    end
  end

  assign lat_o = lat_q;

  // R6 / R8: a latched bit can only become set after a selected event
  a_r6_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & ~$past(lat_q)) != '0) |-> $past(evt));

  // R7: a clear strobe without a competing event empties the latch
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt) |=> (lat_q == '0));

  // R9: moving into the off state disarms the ready trigger
  a_r9_off_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_i == MG_OFF && margin_q != MG_OFF) |=> !arm_q);

  // R9: in ready mode a ready line held high never sets a bit
  a_r9_no_ready_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ready_i && !ready_fall && !clr_i) |=> (lat_q == $past(lat_q)));

endmodule

// File: rtl/dual_fault_monitor.sv
module dual_fault_monitor
  import fmon_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CYC_PER_MS  = 100000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        cmp_in,
  input  logic [NCH-1:0]        cfg_ov_sel,
  input  logic [NCH*FSEL_W-1:0] cfg_filt_sel,
  input  logic                  cfg_supp_margin,
  input  logic                  cfg_latch_on_ready,
  input  logic [1:0]            margin_state,
  input  logic                  ready_in,
  input  logic                  lat_clr,
  output logic                  fault_n,
  output logic [NCH-1:0]        stat_live,
  output logic [NCH-1:0]        stat_lat
);

  localparam int unsigned CNT_W = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [NCH-1:0] cmp_s;
  logic           ready_s;
  logic [NCH-1:0] raw_fault;
  logic [NCH-1:0] live;
  logic [CNT_W-1:0] limit [NCH];
  margin_e        mg;
  logic           suppress;
  logic           fault_act;
  logic           fault_n_q;

  assign mg = margin_e'(margin_state);

  fmon_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cmp_sync (
    .clk (clk), .rst_n (rst_n), .d (cmp_in), .q (cmp_s)
  );

  fmon_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk (clk), .rst_n (rst_n), .d (ready_in), .q (ready_s)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign raw_fault[i] = cfg_ov_sel[i] ? cmp_s[i] : ~cmp_s[i];
      assign limit[i] = CNT_W'(filt_ms(cfg_filt_sel[i*FSEL_W +: FSEL_W]) * CYC_PER_MS);

      fmon_glitch_filter #(.CNT_W(CNT_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_fault[i]),
        .limit_i (limit[i]),
        .filt_o  (live[i])
      );
    end
  endgenerate

  always_comb begin
    suppress  = cfg_supp_margin & ((mg == MG_HIGH) | (mg == MG_LOW));
    fault_act = (|live) & ~suppress;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_n_q <= 1'b1;
    else        fault_n_q <= ~fault_act;
  end

  fmon_latch_ctl #(.NCH(NCH)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_i      (live),
    .fault_act_i (fault_act),
    .ready_s_i   (ready_s),
    .margin_i    (mg),
    .use_ready_i (cfg_latch_on_ready),
    .clr_i       (lat_clr),
    .lat_o       (stat_lat)
  );

  assign fault_n   = fault_n_q;
  assign stat_live = live;

  // R3: no live fault means the output is released one cycle later
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> fault_n);

  // R3: an unsuppressed live fault pulls the output low one cycle later
  a_r3_assert: assert property (@(posedge clk) disable iff (!rst_n)
    ((live != '0) && !suppress) |=> !fault_n);

  // R5: margined high or low with suppression enabled keeps the output released
  a_r5_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_supp_margin && margin_state[1]) |=> fault_n);

endmodule

// File: tb/dual_fault_monitor_tb_top.sv
module dual_fault_monitor_tb_top;

  localparam int unsigned NCH = 2;
  localparam int unsigned CPM = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] cmp_in, cfg_ov_sel, stat_live, stat_lat;
  logic [NCH*3-1:0] cfg_filt_sel;
  logic cfg_supp_margin, cfg_latch_on_ready, ready_in, lat_clr, fault_n;
  logic [1:0] margin_state;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_fault_monitor #(.NCH(NCH), .SYNC_STAGES(2), .CYC_PER_MS(CPM)) dut_i (
    .clk (clk), .rst_n (rst_n), .cmp_in (cmp_in), .cfg_ov_sel (cfg_ov_sel),
    .cfg_filt_sel (cfg_filt_sel), .cfg_supp_margin (cfg_supp_margin),
    .cfg_latch_on_ready (cfg_latch_on_ready), .margin_state (margin_state),
    .ready_in (ready_in), .lat_clr (lat_clr), .fault_n (fault_n),
    .stat_live (stat_live), .stat_lat (stat_lat)
  );

  // vector: {ov[1:0], code0[2:0], code1[2:0], cmp[1:0], margin[1:0], supp, exp_live[1:0], exp_fault_n}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {2'b11, 3'd0, 3'd0, 2'b00, 2'b00, 1'b0, 2'b00, 1'b1},
    {2'b11, 3'd2, 3'd5, 2'b01, 2'b00, 1'b0, 2'b01, 1'b0},
    {2'b00, 3'd7, 3'd1, 2'b01, 2'b00, 1'b0, 2'b10, 1'b0},
    {2'b01, 3'd3, 3'd4, 2'b11, 2'b00, 1'b0, 2'b01, 1'b0},
    {2'b11, 3'd0, 3'd6, 2'b11, 2'b10, 1'b1, 2'b11, 1'b1},
    {2'b11, 3'd0, 3'd0, 2'b11, 2'b11, 1'b1, 2'b11, 1'b1},
    {2'b11, 3'd0, 3'd0, 2'b11, 2'b01, 1'b1, 2'b11, 1'b0},
    {2'b11, 3'd0, 3'd0, 2'b11, 2'b00, 1'b1, 2'b11, 1'b0},
    {2'b11, 3'd0, 3'd0, 2'b11, 2'b10, 1'b0, 2'b11, 1'b0},
    {2'b10, 3'd1, 3'd1, 2'b00, 2'b00, 1'b0, 2'b01, 1'b0}
  };

  function automatic int unsigned win_cyc(input int code);
    int unsigned ms;
    case (code)
      0: ms = 0;    1: ms = 10;   2: ms = 20;   3: ms = 40;
      4: ms = 80;   5: ms = 100;  6: ms = 120;  default: ms = 140;
    endcase
    return ms * CPM;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic clr_pulse();
    lat_clr = 1'b1;
    cyc(1);
    lat_clr = 1'b0;
    cyc(2);
  endtask

  task automatic ready_drop();
    ready_in = 1'b0;
    cyc(4);
    ready_in = 1'b1;
    cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmp_in = '0; cfg_ov_sel = 2'b11; cfg_filt_sel = '0;
    cfg_supp_margin = 1'b0; cfg_latch_on_ready = 1'b0;
    margin_state = 2'b00; ready_in = 1'b1; lat_clr = 1'b0;
    cyc(3);
    // R10: reset state
    chk("R10 fault_n", {7'd0, fault_n}, 8'd1);
    chk("R10 live", {6'd0, stat_live}, 8'd0);
    chk("R10 lat", {6'd0, stat_lat}, 8'd0);
    rst_n = 1'b1;
    cyc(1);
    chk("R10 fault_n after release", {7'd0, fault_n}, 8'd1);

    // R1 R3 R4 R5: steady patterns
    for (int v = 0; v < NV; v++) begin
      cfg_ov_sel      = VEC[v][15:14];
      cfg_filt_sel    = {VEC[v][10:8], VEC[v][13:11]};
      cmp_in          = VEC[v][7:6];
      margin_state    = VEC[v][5:4];
      cfg_supp_margin = VEC[v][3];
      cyc(300);
      chk("R1/R4 live", {6'd0, stat_live}, {6'd0, VEC[v][2:1]});
      chk("R3/R5 fault_n", {7'd0, fault_n}, {7'd0, VEC[v][0]});
    end

    // R2: every filter code in both directions on channel 0
    cfg_ov_sel = 2'b11; cmp_in = 2'b00; margin_state = 2'b00;
    cfg_supp_margin = 1'b0; cfg_filt_sel = '0;
    cyc(300);
    for (int c = 0; c < 8; c++) begin
      cfg_filt_sel = {3'd0, 3'(c)};
      cyc(2);
      cmp_in[0] = 1'b1;
      cyc(win_cyc(c) + 1);
      chk("R2 assert too early", {7'd0, stat_live[0]}, 8'd0);
      cyc(3);
      chk("R2 assert after window", {7'd0, stat_live[0]}, 8'd1);
      cmp_in[0] = 1'b0;
      cyc(win_cyc(c) + 1);
      chk("R2 release too early", {7'd0, stat_live[0]}, 8'd1);
      cyc(3);
      chk("R2 release after window", {7'd0, stat_live[0]}, 8'd0);
    end

    // R2: short pulse rejected (code 3 = 80 cycles)
    cfg_filt_sel = {3'd0, 3'd3};
    cyc(2);
    cmp_in[0] = 1'b1;
    cyc(40);
    cmp_in[0] = 1'b0;
    cyc(200);
    chk("R2 glitch rejected", {6'd0, stat_live}, 8'd0);
    chk("R2 glitch fault_n", {7'd0, fault_n}, 8'd1);

    // R6 R7: fault-edge latching
    cfg_filt_sel = '0;
    clr_pulse();
    cmp_in = 2'b01;
    cyc(10);
    chk("R6 latch on fault edge", {6'd0, stat_lat}, 8'h01);
    clr_pulse();
    chk("R7 clear while fault persists", {6'd0, stat_lat}, 8'h00);
    cmp_in = 2'b11;
    cyc(10);
    chk("R6 no relatch while output active", {6'd0, stat_lat}, 8'h00);
    cmp_in = 2'b00;
    cyc(10);
    cmp_in = 2'b10;
    cyc(10);
    chk("R6 new leading edge", {6'd0, stat_lat}, 8'h02);
    cmp_in = 2'b00;
    cyc(10);
    margin_state = 2'b10; cfg_supp_margin = 1'b1;
    cyc(4);
    clr_pulse();
    cmp_in = 2'b01;
    cyc(10);
    chk("R5/R6 suppressed output gives no edge", {6'd0, stat_lat}, 8'h00);
    ready_drop();
    chk("R9 ready ignored in fault mode", {6'd0, stat_lat}, 8'h00);

    // R8 R9: ready-triggered latching
    cmp_in = 2'b00; margin_state = 2'b00; cfg_supp_margin = 1'b0;
    cfg_latch_on_ready = 1'b1;
    do_reset();
    cmp_in = 2'b01;
    cyc(10);
    chk("R9 fault edge ignored in ready mode", {6'd0, stat_lat}, 8'h00);
    ready_drop();
    chk("R9 no move since reset", {6'd0, stat_lat}, 8'h00);
    margin_state = 2'b01; cyc(3);
    ready_drop();
    chk("R8 off to nominal", {6'd0, stat_lat}, 8'h01);
    clr_pulse();
    margin_state = 2'b00; cyc(3);
    ready_drop();
    chk("R9 move into off", {6'd0, stat_lat}, 8'h00);
    margin_state = 2'b10; cyc(3);
    ready_drop();
    chk("R8 off to high", {6'd0, stat_lat}, 8'h01);
    clr_pulse();
    margin_state = 2'b11; cyc(3);
    ready_drop();
    chk("R9 high to low", {6'd0, stat_lat}, 8'h00);
    margin_state = 2'b01; cyc(3);
    ready_drop();
    chk("R8 low to nominal", {6'd0, stat_lat}, 8'h01);
    clr_pulse();
    cmp_in = 2'b10; cyc(10);
    margin_state = 2'b11; cyc(3);
    ready_drop();
    chk("R8 nominal to low", {6'd0, stat_lat}, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule